// File: doc/BRIEF.md
# Sixteen-Bit Event Timer with Compare-Driven Clear

This block is a 16-bit up-counter. Its source is either a one-cycle internal tick enable or the rising edges of an external count pin. A prescaler sits in front of the counter and passes one source event in 1, 2, 4 or 8. Two special-event trigger inputs come from separate compare channels. They are ORed together, and the result clears the counter. This lets a compare value outside the block act as the timer's period.

Software reaches the block through a byte-wide write port that holds four registers:

| Address | Register |
|---|---|
| 0 | Control byte |
| 1 | Counter low byte |
| 2 | Counter high byte |
| 3 | Overflow flag |

The counter, the control byte and the overflow flag are visible on output pins.

There are two reset inputs. `por_n` is the power-on or brown-out reset. It clears the control byte, the flag, the prescaler and the pin synchronizer. `dev_rst_n` is any other device reset. It clears only the prescaler and the synchronizer. Neither reset touches the counter value.

The block has a sleep input. While it is high, counting continues only in asynchronous external mode. A wake request is raised from a pending overflow when the timer is on and both interrupt enables are set.

Top module: `evt_timer16`

## Requirements
- R1: Control byte at address 0 has these fields: bit 0 run, bit 1 external source select, bit 2 asynchronous mode, bits 4:3 prescale select. `por_n` low clears the control byte to 0, which stops the timer and selects 1:1. `dev_rst_n` leaves the control byte unchanged.
- R2: Neither `por_n` nor `dev_rst_n` changes the counter value. Only a trigger or a write changes it, apart from counting.
- R3: With run=1 and source select=0, each cycle with `tick_en` high is one source event. With run=0, the counter holds.
- R4: Prescale select values map to these ratios: 0 is 1:1, 1 is 1:2, 2 is 1:4, 3 is 1:8. A write to either counter byte clears the prescaler phase.
- R5: With source select=1, each rising edge of `ext_cnt` is one source event. It is counted two clock edges after the pin is sampled high.
- R6: A high `trig_a` or `trig_b` clears the counter to 0 on the next edge. The exception is when source select and asynchronous mode are both 1; then the trigger has no effect.
- R7: A write to counter byte address 1 (low) or 2 (high) in the same cycle as a trigger takes priority. The written byte takes the data, and the other byte keeps its value.
- R8: A count from 16'hFFFF to 16'h0000 sets the overflow flag, which stays set. A write to address 3 loads the flag from data bit 0. A same-cycle overflow wins over that write.
- R9: While `sleep` is high, counting stops unless source select and asynchronous mode are both 1.
- R10: `wake_req` is high exactly when the flag, run, `tmr_ie` and `periph_ie` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on/brown-out reset, active low, asynchronous |
| dev_rst_n | input | 1 | Other device reset, active low, asynchronous |
| tick_en | input | 1 | Internal count enable, one cycle per tick |
| ext_cnt | input | 1 | External count pin, asynchronous |
| trig_a | input | 1 | Special-event trigger from compare channel A |
| trig_b | input | 1 | Special-event trigger from compare channel B |
| sleep | input | 1 | Device sleep state |
| tmr_ie | input | 1 | Timer interrupt enable |
| periph_ie | input | 1 | Peripheral interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 low, 2 high, 3 flag) |
| wr_data | input | 8 | Register write data |
| cnt | output | 16 | Current counter value |
| ctrl_q | output | 8 | Current control byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| wake_req | output | 1 | Wake request |

## Verification
A corrupted prescaler phase shows up as a counter that moves too early or too late. The bench catches it within one prescale period of a known counter write, because every vector restarts from a write that clears that phase. A trigger decoded with the wrong mode or the wrong priority is visible on `cnt` one edge after the trigger. A flag that is not sticky, or a wrong wake gate, appears on `ovf_flag` or `wake_req` in the cycle after the wrap. Reset faults show as a changed counter or control byte right after the reset pulse releases.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_CNT_LO = 2'd1,
    A_CNT_HI = 2'd2,
    A_FLAG   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [2:0] rsvd;
    logic [1:0] ps_sel;
    logic       async_m;
    logic       ext_sel;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/evt_ext_sync.sv
module evt_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;

  // R5
  ext_rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/evt_prescale.sv
module evt_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic             in_pulse,
  output logic             out_pulse
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] acc_q;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = '0;
    for (int i = 0; i < DIV_W; i++)
      if (i < int'(sel)) limit[i] = 1'b1;
  end

  assign out_pulse = in_pulse & (acc_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr)        acc_q <= '0;
    else if (out_pulse)  acc_q <= '0;
    else if (in_pulse)   acc_q <= acc_q + 1'b1;
  end

  // R4
  ps_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pulse && !clr) |=> (acc_q == '0));
  // R4
  ps_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 inc,
  input  logic                 trig,
  input  logic [CNT_W/8-1:0]   wr_byte,
  input  logic                 wr_flag,
  input  logic [7:0]           wr_data,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 ovf_q
);
  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0] merged;
  logic [CNT_W-1:0] nxt;
  logic             any_wr;
  logic             inc_ok;
  logic             wrap;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[b*8 +: 8] = wr_byte[b] ? wr_data : cnt_q[b*8 +: 8];
  end

  assign any_wr = |wr_byte;
  assign inc_ok = inc & ~any_wr & ~trig;
  assign wrap   = inc_ok & (&cnt_q);

  always_comb begin
    if (any_wr)      nxt = merged;
    else if (trig)   nxt = '0;
    else if (inc_ok) nxt = cnt_q + 1'b1;
    else             nxt = cnt_q;
  end

  always_ff @(posedge clk) cnt_q <= nxt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       ovf_q <= 1'b0;
    else if (wrap)    ovf_q <= 1'b1;
    else if (wr_flag) ovf_q <= wr_data[0];
  end

  // R7
  wr_beats_trig_chk: assert property (@(posedge clk) disable iff (!por_n)
    (trig && wr_byte[0]) |=> (cnt_q[7:0] == $past(wr_data)));
  // R6
  trig_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (trig && !any_wr) |=> (cnt_q == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!inc && !trig && !any_wr) |=> $stable(cnt_q));
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    (inc && !trig && !any_wr && (&cnt_q)) |=> (ovf_q && cnt_q == '0));
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PS_SEL_W  = 2,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             dev_rst_n,
  input  logic             tick_en,
  input  logic             ext_cnt,
  input  logic             trig_a,
  input  logic             trig_b,
  input  logic             sleep,
  input  logic             tmr_ie,
  input  logic             periph_ie,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic [7:0]       ctrl_q,
  output logic             ovf_flag,
  output logic             wake_req
);
  localparam int NB = CNT_W / 8;

  ctrl_t          ctrl_r;
  logic           any_rst_n;
  logic           ext_rise;
  logic           src_evt;
  logic           awake_ok;
  logic           pre_in;
  logic           pre_out;
  logic           trig_eff;
  logic           async_ext;
  logic [NB-1:0]  wr_byte;
  logic           wr_flag;

  assign any_rst_n = por_n & dev_rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      ctrl_r <= '0;
    else if (wr_en && reg_addr_e'(wr_addr) == A_CTRL)
      ctrl_r <= ctrl_t'({3'b000, wr_data[4:0]});
  end

  for (genvar b = 0; b < NB; b++) begin : g_wsel
    assign wr_byte[b] = wr_en && (int'(wr_addr) == b + 1);
  end
  assign wr_flag = wr_en && reg_addr_e'(wr_addr) == A_FLAG;

  evt_ext_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (any_rst_n),
    .pin   (ext_cnt),
    .rise  (ext_rise)
  );

  assign async_ext = ctrl_r.ext_sel & ctrl_r.async_m;
  assign src_evt   = ctrl_r.ext_sel ? ext_rise : tick_en;
  assign awake_ok  = ~sleep | async_ext;
  assign pre_in    = ctrl_r.run & awake_ok & src_evt;
  assign trig_eff  = (trig_a | trig_b) & ~async_ext;

  evt_prescale #(.SEL_W(PS_SEL_W)) u_ps (
    .clk       (clk),
    .rst_n     (any_rst_n),
    .clr       (|wr_byte),
    .sel       (ctrl_r.ps_sel),
    .in_pulse  (pre_in),
    .out_pulse (pre_out)
  );

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .por_n   (por_n),
    .inc     (pre_out),
    .trig    (trig_eff),
    .wr_byte (wr_byte),
    .wr_flag (wr_flag),
    .wr_data (wr_data),
    .cnt_q   (cnt),
    .ovf_q   (ovf_flag)
  );

  assign ctrl_q   = ctrl_r;
  assign wake_req = ovf_flag & ctrl_r.run & tmr_ie & periph_ie;

  // R10
  wake_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    wake_req |-> (ovf_flag && tmr_ie && periph_ie));
  // R1
  ctrl_dev_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!dev_rst_n && !wr_en) |=> $stable(ctrl_q));
  // R9
  sleep_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sleep && !async_ext) |-> !pre_in);
endmodule

// File: tb/evt_timer16_tb.sv
module evt_timer16_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, dev_rst_n = 1'b1;
  logic        tick_en = 0, ext_cnt = 0, trig_a = 0, trig_b = 0;
  logic        sleep = 0, tmr_ie = 0, periph_ie = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] cnt;
  logic [7:0]  ctrl_q;
  logic        ovf_flag, wake_req;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  evt_timer16 u_dut (
    .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .tick_en(tick_en),
    .ext_cnt(ext_cnt), .trig_a(trig_a), .trig_b(trig_b), .sleep(sleep),
    .tmr_ie(tmr_ie), .periph_ie(periph_ie), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt(cnt), .ctrl_q(ctrl_q), .ovf_flag(ovf_flag),
    .wake_req(wake_req)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] start;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h01, 16'h0010, 8'd5,  16'h0015, 1'b0},  // R3 internal 1:1
    '{8'h09, 16'h0000, 8'd8,  16'h0004, 1'b0},  // R4 1:2
    '{8'h11, 16'h00FE, 8'd16, 16'h0102, 1'b0},  // R4 1:4
    '{8'h19, 16'h0000, 8'd20, 16'h0002, 1'b0},  // R4 1:8
    '{8'h01, 16'hFFFE, 8'd3,  16'h0001, 1'b1},  // R8 wrap
    '{8'h00, 16'h1234, 8'd7,  16'h1234, 1'b0},  // R3 off
    '{8'h03, 16'h0100, 8'd4,  16'h0104, 1'b0},  // R5 ext sync
    '{8'h07, 16'h0000, 8'd3,  16'h0003, 1'b0}   // R5 ext async
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
    end
  endtask

  task automatic ext_pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_cnt = 1;
      repeat (3) @(negedge clk);
      ext_cnt = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    por_n = 1;
    idle(2);
    // R1 reset state
    chk("R1 ctrl after por", {8'h0, ctrl_q}, 16'h0000);
    chk("R8 flag after por", {15'h0, ovf_flag}, 16'h0000);
    chk("R10 wake after por", {15'h0, wake_req}, 16'h0000);

    // table walk
    foreach (VECS[k]) begin
      wr(2'd0, VECS[k].ctrl);
      set_cnt(VECS[k].start);
      wr(2'd3, 8'h00);
      if (VECS[k].ctrl[1]) ext_pulses(int'(VECS[k].n));
      else ticks(int'(VECS[k].n));
      idle(4);
      chk($sformatf("R3/R4/R5/R8 vec%0d cnt", k), cnt, VECS[k].exp_cnt);
      chk($sformatf("R8 vec%0d flag", k), {15'h0, ovf_flag}, {15'h0, VECS[k].exp_flag});
    end

    // R2 counter survives both resets; R1 ctrl survives dev reset only
    wr(2'd0, 8'h10);
    set_cnt(16'hABCD);
    @(negedge clk); dev_rst_n = 0; idle(2); dev_rst_n = 1; idle(2);
    chk("R1 ctrl kept on dev reset", {8'h0, ctrl_q}, 16'h0010);
    chk("R2 cnt kept on dev reset", cnt, 16'hABCD);
    @(negedge clk); por_n = 0; idle(2); por_n = 1; idle(2);
    chk("R1 ctrl cleared on por", {8'h0, ctrl_q}, 16'h0000);
    chk("R2 cnt kept on por", cnt, 16'hABCD);

    // R6 trigger clears in timer mode, both channels
    wr(2'd0, 8'h01);
    set_cnt(16'h0500);
    @(negedge clk); trig_a = 1; @(negedge clk); trig_a = 0; idle(1);
    chk("R6 trig_a clears", cnt, 16'h0000);
    set_cnt(16'h0600);
    @(negedge clk); trig_b = 1; @(negedge clk); trig_b = 0; idle(1);
    chk("R6 trig_b clears", cnt, 16'h0000);
    // R6 ignored in async external mode
    wr(2'd0, 8'h07);
    set_cnt(16'h0500);
    @(negedge clk); trig_a = 1; @(negedge clk); trig_a = 0; idle(1);
    chk("R6 trig ignored async", cnt, 16'h0500);

    // R7 write beats trigger
    wr(2'd0, 8'h01);
    set_cnt(16'h0300);
    @(negedge clk); wr_en = 1; wr_addr = 2'd1; wr_data = 8'h77; trig_b = 1;
    @(negedge clk); wr_en = 0; trig_b = 0; idle(1);
    chk("R7 write wins over trig", cnt, 16'h0377);

    // R9 sleep stops timer and sync ext; async ext keeps counting
    sleep = 1;
    wr(2'd0, 8'h01);
    set_cnt(16'h0040);
    ticks(4); idle(2);
    chk("R9 sleep internal holds", cnt, 16'h0040);
    wr(2'd0, 8'h03);
    ext_pulses(2); idle(4);
    chk("R9 sleep sync ext holds", cnt, 16'h0040);

    // R10 wake from async overflow in sleep
    wr(2'd0, 8'h07);
    set_cnt(16'hFFFF);
    wr(2'd3, 8'h00);
    tmr_ie = 1; periph_ie = 1;
    ext_pulses(1); idle(4);
    chk("R9 async counts in sleep", cnt, 16'h0000);
    chk("R8 flag on wrap", {15'h0, ovf_flag}, 16'h0001);
    chk("R10 wake raised", {15'h0, wake_req}, 16'h0001);
    @(negedge clk); periph_ie = 0; #1;
    chk("R10 wake gated by periph_ie", {15'h0, wake_req}, 16'h0000);
    wr(2'd3, 8'h00); idle(1);
    chk("R8 flag cleared by write", {15'h0, ovf_flag}, 16'h0000);
    sleep = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule